// File: doc/BRIEF.md
# Modem Status Register Logic

This block produces the modem status byte of a 16550-style serial port. Four active-low modem lines (clear-to-send, data-set-ready, ring, carrier detect) come in from the pins. Each line passes through a two-flop synchronizer. The block reports the inverted level of each line in the upper nibble of the status byte. A change on any line sets a sticky flag in the lower nibble. The flags stay set until the host reads the register.

When loopback is enabled, the four modem-control outputs of the port take the place of the pins. The control outputs are request-to-send, data-terminal-ready and the two user outputs. Change detection then works on these substituted signals. An interrupt request goes out while any change flag is set and the interrupt enable input is high.

Top module: `mstat_reg`

## Requirements
- R1: Status bit 0 becomes 1 when the clear-to-send level changes in either direction, and stays 1 until a read.
- R2: Status bit 1 becomes 1 when the data-set-ready level changes in either direction.
- R3: Status bit 2 becomes 1 only when the ring pin rises from low to high, which is the end of a ring, seen as status bit 6 going from 1 to 0. A ring pin falling from high to low never sets bit 2.
- R4: Status bit 3 becomes 1 when the carrier-detect level changes in either direction.
- R5: With loopback off, status bits 4, 5, 6 and 7 equal the inverse of the clear-to-send, data-set-ready, ring and carrier-detect pins.
- R6: With loopback on, status bits 4, 5, 6 and 7 equal the request-to-send, data-terminal-ready, user-output-1 and user-output-2 control bits, and the pins have no effect on the status byte.
- R7: In loopback, bits 0 to 3 are set by changes of the substituted control bits, following the rules of R1 to R4.
- R8: A one-cycle read strobe clears bits 0 to 3 at the next clock edge. Without a read strobe, a flag that is set stays set.
- R9: A change detected in the same cycle as the read strobe is latched, and its flag is 1 after the read.
- R10: The interrupt output is 1 exactly when the interrupt enable input is 1 and at least one of bits 0 to 3 is 1.
- R11: A pin change shows in the status level bits after two rising clock edges, and in the flag bits after three. After reset the status byte is 0 and the interrupt output is 0, with the pins held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle strobe for a host read of the register |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| loop_en | input | 1 | Loopback enable |
| rts_ctl | input | 1 | Request-to-send control bit |
| dtr_ctl | input | 1 | Data-terminal-ready control bit |
| out1_ctl | input | 1 | User output 1 control bit |
| out2_ctl | input | 1 | User output 2 control bit |
| msi_en | input | 1 | Modem status interrupt enable |
| status | output | 8 | Status byte: levels in bits 7..4, change flags in bits 3..0 |
| irq | output | 1 | Modem status interrupt request |

## Verification
The assertions check these properties on every cycle:
- Flags hold without a read.
- A read with no new event leaves every flag at 0.
- Every detected event is latched, even when it coincides with a read.
- No flag rises without an event.
- A ring event only happens when bit 6 is 0.
- The loopback level substitution holds.
- The interrupt gating holds.

The bench scenarios show the rest:
- Which pin transitions count as events, including that a falling ring pin does not.
- The two-edge synchronizer latency.
- That pins are ignored in loopback.
- That leaving loopback raises deltas against the pin levels.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int MS_LINES = 4;
  localparam int MS_WIDTH = 2 * MS_LINES;
  typedef logic [MS_LINES-1:0] ms_vec_t;

  // Line index order: 0 clear-to-send, 1 set-ready, 2 ring, 3 carrier.
  localparam int MS_RING_IDX = 2;
  localparam ms_vec_t MS_TRAIL_MASK = ms_vec_t'(1) << MS_RING_IDX;

  // Reported level: control bits in loopback, otherwise inverted pins.
  function automatic ms_vec_t pick_level(input logic loop, input ms_vec_t ctl,
                                         input ms_vec_t pin_n);
    return loop ? ctl : ~pin_n;
  endfunction

  // Both-edge change on plain lines, 1->0 of the reported level on masked lines.
  function automatic ms_vec_t detect_change(input ms_vec_t prev, input ms_vec_t cur,
                                            input ms_vec_t trail);
    return ((prev ^ cur) & ~trail) | (prev & ~cur & trail);
  endfunction
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mstat_delta.sv
module mstat_delta
  import mstat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ms_vec_t cur,
  output ms_vec_t evt
);
  ms_vec_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= cur;
  end

  assign evt = detect_change(prev_q, cur, MS_TRAIL_MASK);
endmodule

// File: rtl/mstat_flags.sv
module mstat_flags
  import mstat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  ms_vec_t evt,
  output ms_vec_t flags
);
  ms_vec_t flag_q;

  // A read clears old flags, but an event in the same cycle survives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else flag_q <= (clr ? '0 : flag_q) | evt;
  end

  assign flags = flag_q;
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
  import mstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_stb,
  input  logic                cts_n,
  input  logic                dsr_n,
  input  logic                ri_n,
  input  logic                dcd_n,
  input  logic                loop_en,
  input  logic                rts_ctl,
  input  logic                dtr_ctl,
  input  logic                out1_ctl,
  input  logic                out2_ctl,
  input  logic                msi_en,
  output logic [MS_WIDTH-1:0] status,
  output logic                irq
);
  ms_vec_t pin_raw_n;
  ms_vec_t pin_sync_n;
  ms_vec_t ctl_vec;
  ms_vec_t line_lvl;
  ms_vec_t line_evt;
  ms_vec_t flag_q;

  assign pin_raw_n = {dcd_n, ri_n, dsr_n, cts_n};
  assign ctl_vec   = {out2_ctl, out1_ctl, dtr_ctl, rts_ctl};

  mstat_sync #(.W(MS_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw_n), .q(pin_sync_n)
  );

  assign line_lvl = pick_level(loop_en, ctl_vec, pin_sync_n);

  mstat_delta u_delta (
    .clk(clk), .rst_n(rst_n), .cur(line_lvl), .evt(line_evt)
  );

  mstat_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr(rd_stb), .evt(line_evt), .flags(flag_q)
  );

  assign status = {line_lvl, flag_q};
  assign irq    = msi_en & (|flag_q);
endmodule

// File: rtl/mstat_chk.sv
module mstat_chk
  import mstat_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                rd_stb,
  input logic                loop_en,
  input logic                msi_en,
  input ms_vec_t             ctl,
  input ms_vec_t             evt,
  input logic [MS_WIDTH-1:0] status,
  input logic                irq
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0]))); // R8
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && evt == '0) |=> (status[3:0] == '0)); // R8
  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status[3:0] & $past(evt)) == $past(evt))); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[3:0] & ~$past(status[3:0]) & ~$past(evt)) == '0)); // R1
  AST_RING_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    evt[MS_RING_IDX] |-> !status[4+MS_RING_IDX]); // R3
  AST_LOOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (status[7:4] == ctl)); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq); // R10
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en && status[3:0] != '0) |-> irq); // R10
endmodule

bind mstat_reg mstat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .loop_en(loop_en), .msi_en(msi_en),
  .ctl({out2_ctl, out1_ctl, dtr_ctl, rts_ctl}), .evt(line_evt),
  .status(status), .irq(irq)
);

// File: tb/mstat_reg_test.sv
`timescale 1ns/1ps
module mstat_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 1'b0;
  logic [3:0] pins_n = 4'b1111;   // {dcd, ri, dsr, cts}
  logic loop_en = 1'b0;
  logic [3:0] ctl = 4'b0000;      // {out2, out1, dtr, rts}
  logic msi_en = 1'b1;
  logic [7:0] status;
  logic irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mstat_reg uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
    .cts_n(pins_n[0]), .dsr_n(pins_n[1]), .ri_n(pins_n[2]), .dcd_n(pins_n[3]),
    .loop_en(loop_en), .rts_ctl(ctl[0]), .dtr_ctl(ctl[1]),
    .out1_ctl(ctl[2]), .out2_ctl(ctl[3]), .msi_en(msi_en),
    .status(status), .irq(irq)
  );

  // pins, loop, ctl, msi_en, read-after, expected status, expected irq
  localparam logic [19:0] VEC [12] = '{
    {4'b1110, 1'b0, 4'b0000, 1'b1, 1'b1, 8'h11, 1'b1}, // R1 R5 cts asserted
    {4'b1010, 1'b0, 4'b0000, 1'b1, 1'b1, 8'h50, 1'b0}, // R3 ring start: no flag
    {4'b1110, 1'b0, 4'b0000, 1'b1, 1'b1, 8'h14, 1'b1}, // R3 ring end: flag
    {4'b0100, 1'b0, 4'b0000, 1'b0, 1'b1, 8'hBA, 1'b0}, // R2 R4 R10 masked
    {4'b0100, 1'b0, 4'b0000, 1'b1, 1'b0, 8'hB0, 1'b0}, // R8 cleared by read
    {4'b1111, 1'b0, 4'b0000, 1'b1, 1'b0, 8'h0B, 1'b1}, // R1 R2 R4 deassert
    {4'b1111, 1'b0, 4'b0000, 1'b1, 1'b1, 8'h0B, 1'b1}, // R8 sticky
    {4'b1111, 1'b1, 4'b0101, 1'b1, 1'b1, 8'h51, 1'b1}, // R6 R7 loopback
    {4'b1111, 1'b1, 4'b0001, 1'b1, 1'b1, 8'h14, 1'b1}, // R7 out1 fall
    {4'b0000, 1'b1, 4'b0001, 1'b1, 1'b1, 8'h10, 1'b0}, // R6 pins ignored
    {4'b0000, 1'b0, 4'b0001, 1'b1, 1'b1, 8'hFA, 1'b1}, // R5 leave loopback
    {4'b0000, 1'b0, 4'b0001, 1'b1, 1'b1, 8'hF0, 1'b0}  // R10 no flags
  };

  task automatic chk(input string req, input logic [7:0] st_exp, input logic irq_exp);
    checks++;
    if (status !== st_exp || irq !== irq_exp) begin
      failures++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               req, status, irq, st_exp, irq_exp);
    end
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset", 8'h00, 1'b0);

    for (int i = 0; i < 12; i++) begin
      pins_n  = VEC[i][19:16];
      loop_en = VEC[i][15];
      ctl     = VEC[i][14:11];
      msi_en  = VEC[i][10];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R1-R10 vector %0d", i), VEC[i][8:1], VEC[i][0]);
      if (VEC[i][9]) do_read();
    end

    // Set a data-set-ready flag first.
    pins_n = 4'b0010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 dsr flag", 8'hD2, 1'b1);
    // A cts change lands in the same cycle as the read.
    pins_n = 4'b0011;
    @(negedge clk);
    chk("R11 one edge no change", 8'hD2, 1'b1);
    @(negedge clk);
    chk("R11 level after two edges", 8'hC2, 1'b1);
    do_read();
    chk("R9 coincident change kept", 8'hC1, 1'b1);
    @(negedge clk);
    chk("R9 flag still held", 8'hC1, 1'b1);
    do_read();
    chk("R8 read clears", 8'hC0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule